// File: doc/BRIEF.md
# Single-Pin Pulse-Count Mode Selector

This block turns one active-low enable line into an operating mode number. While the line is held low, the block reports shutdown. A host leaves shutdown by raising the line, and it may send further short low-high pulses. Each accepted rising edge raises the mode by one. When the line has then stayed high for a fixed settle time, the count becomes the latched mode.

Once a mode is latched, more rising edges are locked out. A stray pulse from the host cannot move the amplifier to another mode. Only a long low period on the line returns the block to shutdown, and that clears the mode. The raw line first passes through a synchronizer and then through a stability filter, so narrow spikes never reach the edge counter.

Timing is expressed in clock cycles per microsecond (`CYC_PER_US`). The filter window, the latch delay and the turn-off delay are all derived from it. The defaults are a 0.5 µs filter, a 300 µs latch delay and a 300 µs turn-off delay.

Top module: `pulse_mode_decoder`

## Requirements
- R1: After reset `shutdown` is 1, `mode_valid` is 0 and `mode` is 0.
- R2: From shutdown, N accepted rising edges (N from 1 to 10), each high pulse and low gap lasting 1 µs to 10 µs, latch `mode` = N as a 4-bit binary number with `mode_valid` = 1.
- R3: More than ten rising edges latch mode 10; `mode` never exceeds 10.
- R4: A high or low excursion of `pin_n` shorter than the 0.5 µs filter window is not seen. It neither counts as an edge nor leaves shutdown.
- R5: The mode latches only once the line has been high for 300 µs after the last rising edge. `mode_valid` is still 0 280 µs after that edge and is 1 by 320 µs.
- R6: While a mode is latched, further pulses on `pin_n` leave `mode` and `mode_valid` unchanged.
- R7: A low period of 300 µs on `pin_n` sets `shutdown`, clears `mode_valid` and sets `mode` to 0. A low period of 100 µs after latching is ignored and does not restart counting.
- R8: `shutdown` falls on the first accepted rising edge, well before the mode latches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, `CYC_PER_US` cycles per microsecond |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_n | input | 1 | Raw enable/control line, low means shut down |
| mode | output | 4 | Latched mode number 1..10, 0 when not latched |
| mode_valid | output | 1 | High while a mode is latched |
| shutdown | output | 1 | High while the line is held in shutdown |

## Verification
A wrong edge count shows up as a wrong `mode` at the moment `mode_valid` rises, about 300 µs after the burst. A broken lockout shows up as a changed `mode` within one latch delay of a stray burst. A broken filter shows up either as a mode one higher than the number of clean pulses or as `shutdown` dropping on a lone spike. A stuck turn-off timer shows up as `shutdown` still low 320 µs after the line falls, or as a mode surviving a short low dip in the wrong way.

// File: rtl/pulse_mode_decoder.sv
module pulse_mode_decoder #(
  parameter int CYC_PER_US = 8,
  parameter int LATCH_US   = 300,
  parameter int OFF_US     = 300,
  parameter int MAX_MODE   = 10
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pin_n,
  output logic [3:0] mode,
  output logic       mode_valid,
  output logic       shutdown
);

  localparam int DG_CYC    = (CYC_PER_US / 2 < 1) ? 1 : CYC_PER_US / 2;
  localparam int DW        = $clog2(DG_CYC + 1);
  localparam int LATCH_CYC = LATCH_US * CYC_PER_US;
  localparam int OFF_CYC   = OFF_US * CYC_PER_US;
  localparam int LIM       = (LATCH_CYC > OFF_CYC) ? LATCH_CYC : OFF_CYC;
  localparam int TW        = $clog2(LIM + 1);

  typedef enum logic [1:0] {ST_SHUT, ST_COUNT, ST_LOCK} st_t;

  logic          s1, s2, lvl, lvl_d;
  logic [DW-1:0] dcnt;
  logic [TW-1:0] tmr;
  logic [3:0]    cnt;
  st_t           st;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      s1 <= 1'b0;
      s2 <= 1'b0;
    end else begin
      s1 <= pin_n;
      s2 <= s1;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      lvl  <= 1'b0;
      dcnt <= '0;
    end else if (s2 == lvl) begin
      dcnt <= '0;
    end else if (dcnt == DW'(DG_CYC - 1)) begin
      lvl  <= s2;
      dcnt <= '0;
    end else begin
      dcnt <= dcnt + 1'b1;
    end

  wire rise = lvl & ~lvl_d;
  wire chg  = lvl ^ lvl_d;
  wire latch_hit = lvl & ~chg & (tmr == TW'(LATCH_CYC - 1));
  wire off_hit   = ~lvl & ~chg & (tmr == TW'(OFF_CYC - 1));

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      lvl_d <= 1'b0;
      tmr   <= '0;
    end else begin
      lvl_d <= lvl;
      if (chg)
        tmr <= '0;
      else if (tmr != TW'(LIM))
        tmr <= tmr + 1'b1;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st  <= ST_SHUT;
      cnt <= '0;
    end else begin
      case (st)
        ST_SHUT:
          if (rise) begin
            st  <= ST_COUNT;
            cnt <= 4'd1;
          end
        ST_COUNT:
          if (rise) begin
            if (cnt != 4'(MAX_MODE))
              cnt <= cnt + 4'd1;
          end else if (latch_hit) begin
            st <= ST_LOCK;
          end else if (off_hit) begin
            st  <= ST_SHUT;
            cnt <= '0;
          end
        ST_LOCK:
          if (off_hit) begin
            st  <= ST_SHUT;
            cnt <= '0;
          end
        default: begin
          st  <= ST_SHUT;
          cnt <= '0;
        end
      endcase
    end

  assign shutdown   = (st == ST_SHUT);
  assign mode_valid = (st == ST_LOCK);
  assign mode       = mode_valid ? cnt : 4'd0;

endmodule

// File: rtl/pulse_mode_decoder_chk.sv
module pulse_mode_decoder_chk #(
  parameter int MAX_MODE = 10
) (
  input logic       clk,
  input logic       rst_n,
  input logic       pin_n,
  input logic [3:0] mode,
  input logic       mode_valid,
  input logic       shutdown
);

  a_r2_valid_range: assert property (@(posedge clk) disable iff (!rst_n)
    mode_valid |-> (mode >= 4'd1 && mode <= 4'(MAX_MODE)));

  a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    mode <= 4'(MAX_MODE));

  a_r6_mode_held: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_valid && $past(mode_valid)) |-> mode == $past(mode));

  a_r7_shut_clears: assert property (@(posedge clk) disable iff (!rst_n)
    shutdown |-> (!mode_valid && mode == 4'd0));

  a_r5_latch_high: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mode_valid) |-> $past(pin_n));

  a_r8_wake_unlatched: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(shutdown) |-> !mode_valid);

endmodule

bind pulse_mode_decoder pulse_mode_decoder_chk #(.MAX_MODE(MAX_MODE)) u_chk (
  .clk(clk), .rst_n(rst_n), .pin_n(pin_n),
  .mode(mode), .mode_valid(mode_valid), .shutdown(shutdown));

// File: tb/pulse_mode_decoder_bench.sv
module pulse_mode_decoder_bench;
  localparam int CPU = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       pin_n = 1'b0;
  logic [3:0] mode;
  logic       mode_valid, shutdown;

  int vecs = 0;
  int errs = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  pulse_mode_decoder u_pulse_mode_decoder (
    .clk(clk), .rst_n(rst_n), .pin_n(pin_n),
    .mode(mode), .mode_valid(mode_valid), .shutdown(shutdown));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    vecs++;
    if (!ok) begin
      errs++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_us(input int u);
    wait_cyc(u * CPU);
  endtask

  task automatic burst(input int n, input int hi_us, input int lo_us);
    for (int i = 0; i < n; i++) begin
      pin_n = 1'b1;
      wait_us(hi_us);
      if (i < n - 1) begin
        pin_n = 1'b0;
        wait_us(lo_us);
      end
    end
  endtask

  task automatic run(input int n, input int hi_us, input int lo_us);
    int exp = (n > 10) ? 10 : n;
    burst(n, hi_us, lo_us);
    chk(shutdown == 1'b0, "R8", shutdown, 0);
    wait_us(280);
    chk(mode_valid == 1'b0, "R5", mode_valid, 0);
    wait_us(40);
    chk(mode_valid == 1'b1, "R5", mode_valid, 1);
    if (n > 10) chk(mode == 4'(exp), "R3", mode, exp);
    else        chk(mode == 4'(exp), "R2", mode, exp);
    pin_n = 1'b0;
    wait_us(320);
    chk(shutdown && !mode_valid && mode == 4'd0, "R7", {mode_valid, mode}, 0);
  endtask

  initial begin
    wait_cyc(5);
    chk(shutdown == 1'b1, "R1", shutdown, 1);
    chk(mode_valid == 1'b0 && mode == 4'd0, "R1", {mode_valid, mode}, 0);
    rst_n = 1'b1;
    wait_cyc(5);
    chk(shutdown == 1'b1 && mode == 4'd0, "R1", {shutdown, mode}, 16);

    for (int n = 1; n <= 12; n++) run(n, 2, 2);
    run(3, 1, 1);
    run(3, 10, 10);
    run(5, 1, 10);

    // R4: lone spike from shutdown
    pin_n = 1'b1; wait_cyc(2); pin_n = 1'b0;
    wait_us(5);
    chk(shutdown == 1'b1, "R4", shutdown, 1);
    // R4: short low dip inside a high and a short high inside a gap
    pin_n = 1'b1; wait_us(1);
    pin_n = 1'b0; wait_cyc(2); pin_n = 1'b1; wait_us(1);
    pin_n = 1'b0; wait_us(2);
    pin_n = 1'b1; wait_cyc(2); pin_n = 1'b0; wait_us(2);
    pin_n = 1'b1;
    wait_us(320);
    chk(mode_valid && mode == 4'd2, "R4", mode, 2);

    // R6: stray burst after latching
    pin_n = 1'b0; wait_us(2);
    burst(4, 2, 2);
    wait_us(350);
    chk(mode_valid && mode == 4'd2, "R6", mode, 2);
    // R7: 100 us low dip ignored
    pin_n = 1'b0; wait_us(100);
    pin_n = 1'b1; wait_us(350);
    chk(mode_valid && !shutdown && mode == 4'd2, "R7", mode, 2);
    pin_n = 1'b0; wait_us(320);
    chk(shutdown && mode == 4'd0, "R7", mode, 0);

    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      vecs++;
      errs++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("  == %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  end
endmodule